// File: doc/BRIEF.md
# Three-Bus Fetch Datapath

This block is the register-transfer core of a small processor front end. It holds a program counter, a memory address register, a memory buffer register and an instruction register, plus a fixed constant of one. The registers do not talk to one another directly. Every move goes through a single ALU: two operand buses (A and B) feed it, and its result bus (C) is the only path back into any register. The program counter can only drive bus A. The buffer register and the constant can only drive bus B.

A sequencer drives plain strobes, one per cycle of work. It picks the bus sources, one ALU operation (pass A, pass B or add) and the destination register. Copying a register always uses a pass operation. Incrementing the program counter means adding the constant on bus B. A read strobe issues a memory read at the address register's value. The returned word lands in the buffer register.

The read side is a request/valid pair. `mem_rd_req` rises in the cycle after the read strobe and presents the address register's current value. The memory may stall by holding `mem_rd_valid` low. The request and address stay up until a cycle in which valid is high, and the buffer register captures `mem_rdata` at that edge. The block never back-pressures the memory. A three-step fetch works at full rate when the memory answers in the same cycle:
1. Address register ← program counter, and read.
2. Program counter ← program counter + 1.
3. Instruction register ← buffer register.

Top module: `tribus_datapath`

## Requirements
- R1: After reset the following are all zero: the program counter, buffer register, instruction register, address register (seen on `mem_addr`), `bus_c` and `mem_rd_req`.
- R2: With `op_pass_a` high, `bus_c` equals bus A in the same cycle. Bus A is the program counter when `pc_to_a` is high and zero otherwise.
- R3: With `op_pass_b` high, `bus_c` equals bus B in the same cycle. Bus B is the buffer register when `mbr_to_b` is high, the value 1 when `one_to_b` is high, and zero when neither is high.
- R4: With `op_add` high, `bus_c` equals bus A plus bus B modulo 2^16. With the program counter on A, one on B and `ld_pc` high, the program counter increments in a single cycle and wraps from 0xFFFF to 0x0000.
- R5: At most one of `mbr_to_b` and `one_to_b` is high in any cycle.
- R6: At most one ALU operation strobe is high per cycle. When none is high, `bus_c` is zero and no destination register loads, even if a load strobe is high.
- R7: At most one of `ld_mar`, `ld_pc` and `ld_ir` is high per cycle. When an operation is active, the selected register takes `bus_c` at the rising edge.
- R8: A read strobe raises `mem_rd_req` from the next cycle, with `mem_addr` equal to the address register. The request is held while `mem_rd_valid` is low. The buffer register loads `mem_rdata` at the edge where request and valid are both high, and is otherwise unchanged.
- R9: Three consecutive fetch steps leave the address register at the old program counter, the program counter at that value plus one, and the instruction register at the memory word at the old program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_to_a | input | 1 | Program counter drives bus A |
| mbr_to_b | input | 1 | Buffer register drives bus B |
| one_to_b | input | 1 | Constant one drives bus B |
| op_pass_a | input | 1 | ALU copies bus A to bus C |
| op_pass_b | input | 1 | ALU copies bus B to bus C |
| op_add | input | 1 | ALU puts A+B on bus C |
| ld_mar | input | 1 | Address register loads bus C |
| ld_pc | input | 1 | Program counter loads bus C |
| ld_ir | input | 1 | Instruction register loads bus C |
| rd_strobe | input | 1 | Start a memory read |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_addr | output | 16 | Read address (address register) |
| mem_rd_valid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 16 | Read data |
| pc_q | output | 16 | Program counter |
| mbr_q | output | 16 | Buffer register |
| ir_q | output | 16 | Instruction register |
| bus_c | output | 16 | ALU result bus |

## Verification
The hardest cases to reach from the ports are the program counter wrapping and a stalled read. To wrap the counter, 0xFFFF has to get into it, and the only way in is through a memory read. The bench therefore uses a memory whose word at address zero is 0xFFFF. It reads that word right after reset, passes it from the buffer register into the program counter, and then adds one twice. Stalls come from a bench-side switch that holds `mem_rd_valid` low for several cycles after a read strobe. While the stall lasts, the bench checks that the request stays up and the buffer register keeps its value. It then releases the stall and checks the capture. Load strobes issued with no ALU operation confirm that the destinations stay put.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_PASS_A = 2'd1,
    OP_PASS_B = 2'd2,
    OP_ADD    = 2'd3
  } alu_op_e;

  localparam int unsigned DST_MAR = 0;
  localparam int unsigned DST_PC  = 1;
  localparam int unsigned DST_IR  = 2;
  localparam int unsigned NUM_DST = 3;
endpackage

// File: rtl/tribus_srcsel.sv
module tribus_srcsel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pc_to_a,
  input  logic         mbr_to_b,
  input  logic         one_to_b,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] mbr,
  input  logic [W-1:0] konst,
  output logic [W-1:0] bus_a,
  output logic [W-1:0] bus_b
);
  // Non-priority AND-OR selection: a single driver per bus is assumed.
  always_comb begin
    bus_a = {W{pc_to_a}} & pc;
    bus_b = ({W{mbr_to_b}} & mbr) | ({W{one_to_b}} & konst);
  end

  // R5
  bsrc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mbr_to_b, one_to_b}) <= 1)
    else $error("two sources on bus B");
endmodule

// File: rtl/tribus_alu.sv
module tribus_alu
  import tribus_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] c
);
  always_comb begin
    unique case (op)
      OP_PASS_A: c = a;
      OP_PASS_B: c = b;
      OP_ADD:    c = a + b;
      default:   c = '0;
    endcase
  end
endmodule

// File: rtl/tribus_dstregs.sv
module tribus_dstregs #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_live,
  input  logic [N-1:0]        ld,
  input  logic [W-1:0]        bus_c,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_dst
    always_ff @(posedge clk) begin
      if (!rst_n)                q[i] <= '0;
      else if (op_live && ld[i]) q[i] <= bus_c;
    end
  end

  // R7
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld))
    else $error("more than one destination loads");

  // R7
  dst_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_live && ld[0]) |=> (q[0] == $past(bus_c)))
    else $error("selected destination missed bus C");

  // R6
  no_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_live |=> $stable(q))
    else $error("destination changed with no ALU operation");
endmodule

// File: rtl/tribus_memport.sv
module tribus_memport #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_strobe,
  input  logic         mem_rd_valid,
  input  logic [W-1:0] mem_rdata,
  output logic         rd_pend,
  output logic [W-1:0] mbr_q
);
  logic take;
  assign take = rd_pend && mem_rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      mbr_q   <= '0;
    end else begin
      rd_pend <= rd_strobe || (rd_pend && !mem_rd_valid);
      if (take) mbr_q <= mem_rdata;
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && !mem_rd_valid) |=> rd_pend)
    else $error("read request dropped before valid");

  // R8
  mbr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && mem_rd_valid) |=> (mbr_q == $past(mem_rdata)))
    else $error("buffer register missed read data");

  // R8
  mbr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pend && mem_rd_valid) |=> $stable(mbr_q))
    else $error("buffer register changed without read data");
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tribus_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pc_to_a,
  input  logic         mbr_to_b,
  input  logic         one_to_b,
  input  logic         op_pass_a,
  input  logic         op_pass_b,
  input  logic         op_add,
  input  logic         ld_mar,
  input  logic         ld_pc,
  input  logic         ld_ir,
  input  logic         rd_strobe,
  output logic         mem_rd_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rd_valid,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] mbr_q,
  output logic [W-1:0] ir_q,
  output logic [W-1:0] bus_c
);
  localparam logic [W-1:0] KONST_ONE = W'(1);

  alu_op_e                     op;
  logic                        op_live;
  logic [W-1:0]                bus_a;
  logic [W-1:0]                bus_b;
  logic [NUM_DST-1:0]          ld_vec;
  logic [NUM_DST-1:0][W-1:0]   dst_q;

  always_comb begin
    if (op_add)         op = OP_ADD;
    else if (op_pass_b) op = OP_PASS_B;
    else if (op_pass_a) op = OP_PASS_A;
    else                op = OP_NONE;
  end
  assign op_live = (op != OP_NONE);

  // R6
  op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_pass_a, op_pass_b, op_add}))
    else $error("more than one ALU operation strobe");

  always_comb begin
    ld_vec          = '0;
    ld_vec[DST_MAR] = ld_mar;
    ld_vec[DST_PC]  = ld_pc;
    ld_vec[DST_IR]  = ld_ir;
  end

  tribus_srcsel #(.W(W)) u_srcsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_to_a  (pc_to_a),
    .mbr_to_b (mbr_to_b),
    .one_to_b (one_to_b),
    .pc       (pc_q),
    .mbr      (mbr_q),
    .konst    (KONST_ONE),
    .bus_a    (bus_a),
    .bus_b    (bus_b)
  );

  tribus_alu #(.W(W)) u_alu (
    .op (op),
    .a  (bus_a),
    .b  (bus_b),
    .c  (bus_c)
  );

  tribus_dstregs #(.W(W), .N(NUM_DST)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_live (op_live),
    .ld      (ld_vec),
    .bus_c   (bus_c),
    .q       (dst_q)
  );

  tribus_memport #(.W(W)) u_mem (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .mem_rd_valid (mem_rd_valid),
    .mem_rdata    (mem_rdata),
    .rd_pend      (mem_rd_req),
    .mbr_q        (mbr_q)
  );

  assign mem_addr = dst_q[DST_MAR];
  assign pc_q     = dst_q[DST_PC];
  assign ir_q     = dst_q[DST_IR];

  // R4
  pc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_add && pc_to_a && one_to_b && ld_pc) |=> (pc_q == $past(pc_q) + W'(1)))
    else $error("program counter increment wrong");
endmodule

// File: tb/tribus_datapath_bench.sv
module tribus_datapath_bench;
  localparam int W = 16;
  localparam logic [9:0] S_PCA  = 10'h001;
  localparam logic [9:0] S_ONEB = 10'h002;
  localparam logic [9:0] S_MBRB = 10'h004;
  localparam logic [9:0] S_PSA  = 10'h008;
  localparam logic [9:0] S_PSB  = 10'h010;
  localparam logic [9:0] S_ADD  = 10'h020;
  localparam logic [9:0] S_LMAR = 10'h040;
  localparam logic [9:0] S_LPC  = 10'h080;
  localparam logic [9:0] S_LIR  = 10'h100;
  localparam logic [9:0] S_RD   = 10'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_to_a = 0, mbr_to_b = 0, one_to_b = 0;
  logic op_pass_a = 0, op_pass_b = 0, op_add = 0;
  logic ld_mar = 0, ld_pc = 0, ld_ir = 0, rd_strobe = 0;
  logic stall = 1'b0;
  logic mem_rd_req, mem_rd_valid;
  logic [W-1:0] mem_addr, mem_rdata, pc_q, mbr_q, ir_q, bus_c;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // bench model state
  logic [W-1:0] m_pc = '0, m_mar = '0, m_mbr = '0, m_ir = '0;
  logic m_pend = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    return ~a ^ {a[7:0], 8'h00};
  endfunction

  assign mem_rd_valid = mem_rd_req & ~stall;
  assign mem_rdata    = memf(mem_addr);

  tribus_datapath #(.W(W)) u_tribus_datapath (
    .clk(clk), .rst_n(rst_n),
    .pc_to_a(pc_to_a), .mbr_to_b(mbr_to_b), .one_to_b(one_to_b),
    .op_pass_a(op_pass_a), .op_pass_b(op_pass_b), .op_add(op_add),
    .ld_mar(ld_mar), .ld_pc(ld_pc), .ld_ir(ld_ir), .rd_strobe(rd_strobe),
    .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rdata(mem_rdata),
    .pc_q(pc_q), .mbr_q(mbr_q), .ir_q(ir_q), .bus_c(bus_c)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: drives one cycle of strobes, checks bus C, pushes the post-edge state
  task automatic step(input logic [9:0] s, input logic st, input string tag);
    logic [W-1:0] a, b, c, pc_n, mar_n, ir_n, mbr_n;
    logic live, vld;
    @(negedge clk);
    {rd_strobe, ld_ir, ld_pc, ld_mar, op_add, op_pass_b, op_pass_a,
     mbr_to_b, one_to_b, pc_to_a} = s;
    stall = st;
    a = s[0] ? m_pc : '0;
    b = s[2] ? m_mbr : (s[1] ? W'(1) : '0);
    live = s[3] | s[4] | s[5];
    c = s[5] ? a + b : (s[4] ? b : (s[3] ? a : '0));
    #1;
    chk({tag, " bus_c"}, {48'd0, bus_c}, {48'd0, c});
    chk("R8 req", {63'd0, mem_rd_req}, {63'd0, m_pend});
    vld   = m_pend & ~st;
    mar_n = (live && s[6]) ? c : m_mar;
    pc_n  = (live && s[7]) ? c : m_pc;
    ir_n  = (live && s[8]) ? c : m_ir;
    mbr_n = vld ? memf(m_mar) : m_mbr;
    m_pend = s[9] | (m_pend & ~vld);
    m_mar = mar_n; m_pc = pc_n; m_ir = ir_n; m_mbr = mbr_n;
    exp_q.push_back({m_mar, m_pc, m_mbr, m_ir});
    tag_q.push_back(tag);
  endtask

  // monitor: compares registers after each driven edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " regs"}, {mem_addr, pc_q, mbr_q, ir_q}, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #200000;
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 regs", {mem_addr, pc_q, mbr_q, ir_q}, 64'd0);
    chk("R1 bus_c/req", {47'd0, mem_rd_req, bus_c}, 64'd0);

    step(S_RD, 1'b0, "R8");                          // read address 0
    step(10'h000, 1'b0, "R8");                       // mbr <= 0xFFFF
    step(S_MBRB | S_PSB | S_LPC, 1'b0, "R3");        // pc <= 0xFFFF
    step(S_PCA | S_ONEB | S_ADD | S_LPC, 1'b0, "R4"); // wrap to 0
    step(S_PCA | S_ONEB | S_ADD | S_LPC, 1'b0, "R4"); // pc = 1
    for (int k = 0; k < 3; k++) begin
      step(S_PCA | S_PSA | S_LMAR | S_RD, 1'b0, "R9");
      step(S_PCA | S_ONEB | S_ADD | S_LPC, 1'b0, "R9");
      step(S_MBRB | S_PSB | S_LIR, 1'b0, "R9");
    end
    // stalled read
    step(S_PCA | S_PSA | S_LMAR | S_RD, 1'b1, "R2");
    step(10'h000, 1'b1, "R8");
    step(10'h000, 1'b1, "R8");
    step(10'h000, 1'b0, "R8");
    // loads with no operation are ignored
    step(S_LPC, 1'b0, "R6");
    step(S_PCA | S_ONEB | S_LIR, 1'b0, "R6");
    step(S_ONEB | S_PSB | S_LMAR, 1'b0, "R7");
    step(S_PSB | S_LIR, 1'b0, "R3");
    step(S_PSA | S_LPC, 1'b0, "R2");
    step(S_MBRB | S_PCA | S_ADD | S_LIR, 1'b0, "R4");
    @(negedge clk);
    {rd_strobe, ld_ir, ld_pc, ld_mar, op_add, op_pass_b, op_pass_a,
     mbr_to_b, one_to_b, pc_to_a} = '0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule